// File: doc/BRIEF.md
# Hysteresis Current Band Controller

This block produces the two gate commands of a grid-connected full bridge. On every valid sample it places a band of fixed half-width around the reference sample, which is the sampled grid voltage itself. It then compares the measured output current with that band. When the current drops under the band, it selects the pair of switches that drives current upward. When the current climbs over the band, it selects the opposite pair. While the current stays inside the band, it keeps whichever pair it selected last. Because the reference is the grid voltage, the injected current follows the grid phase without a phase-locked loop.

Two conditions blank the bridge. The first is the measured DC-link voltage: until it exceeds the arming level, both gates stay off. The second is the reference: when its magnitude lies close to zero, near a grid zero crossing, both gates are turned off. All samples are signed Q8.8 fixed point, so 1.0 is 256 LSB. The gate outputs come straight from the state register, which gives one clock of latency after a valid sample.

The controller has four states. `ST_OFF` means the link is not armed. `ST_IDLE` means the link is armed and no pair is selected. `ST_POS` means the positive pair is on. `ST_NEG` means the negative pair is on. The transitions are:
- Disarm: from any state to `ST_OFF` in the cycle after the link is not above the arming level.
- Arm: from `ST_OFF` to `ST_IDLE` when the link is armed and no sample arrives.
- Blank: on a valid sample whose reference lies inside the dead band, to `ST_IDLE`.
- Fire-up: on a valid sample with the current below the band, to `ST_POS`.
- Fire-down: on a valid sample with the current above the band, to `ST_NEG`.
- Hold: on a valid sample with the current inside the band, stay in the current state (`ST_OFF` moves to `ST_IDLE`).

Top module: `hcb_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in `ST_OFF`, with both `gate_pos` and `gate_neg` at 0.
- R2: On a valid armed sample outside the dead band, a current strictly below reference minus `BAND_LSB` sets `gate_pos`=1 and `gate_neg`=0 on the next clock.
- R3: On a valid armed sample outside the dead band, a current strictly above reference plus `BAND_LSB` sets `gate_neg`=1 and `gate_pos`=0 on the next clock.
- R4: On a valid armed sample outside the dead band, a current inside the band keeps the previously selected pair.
- R5: The band edges are exclusive triggers: a current exactly equal to reference plus or minus `BAND_LSB` counts as inside the band.
- R6: While the DC-link sample is not strictly greater than `ARM_LSB`, both gates are 0 from the next clock onward. After re-arming, both gates stay 0 until a valid sample selects a pair.
- R7: On a valid armed sample whose reference magnitude is at most `DEAD_LSB`, both gates are 0 on the next clock, for either sign of the reference.
- R8: `gate_pos` and `gate_neg` are never 1 in the same cycle.
- R9: Without a sample-valid strobe, the gates do not change while the link stays armed, whatever the current and reference inputs do.
- R10: The band follows the reference in both polarities, so the same rules hold around a negative reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_meas | input | W | Measured output current, signed Q8.8 |
| ref_smp | input | W | Grid-voltage reference sample, signed Q8.8 |
| smp_valid | input | 1 | One-cycle strobe marking a new current/reference pair |
| vdc_meas | input | W | Measured DC-link voltage, signed Q8.8 |
| gate_pos | output | 1 | Command for the positive switch pair |
| gate_neg | output | 1 | Command for the negative switch pair |

## Verification
The bench builds the controller with its defaults: W=16, a band of 256 LSB (1.0), a dead band of 77 LSB (about 0.3), and an arming level of 13824 LSB (54.0). These values put every boundary within one LSB of a directed stimulus. The tests probe a link at exactly 54.0 against 54.0 plus one LSB, references of ±77 against 78, and currents exactly on each band edge against one LSB past it. A closing sweep drives a stepped, sign-changing reference with a current that wanders across the band. It compares every sample against a state model built from the rules above.

// File: rtl/hcb_pkg.sv
package hcb_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_POS  = 2'd2,
        ST_NEG  = 2'd3
    } band_state_t;

endpackage

// File: rtl/hcb_window.sv
module hcb_window #(
    parameter int W        = 16,
    parameter int BAND_LSB = 256
) (
    input  logic signed [W-1:0] i_meas,
    input  logic signed [W-1:0] ref_smp,
    output logic                below,
    output logic                above
);
    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] BAND_X = $signed(XW'(BAND_LSB));

    logic signed [XW-1:0] ref_x;
    logic signed [XW-1:0] cur_x;
    logic signed [XW-1:0] upper;
    logic signed [XW-1:0] lower;

    always_comb begin
        ref_x = {{2{ref_smp[W-1]}}, ref_smp};
        cur_x = {{2{i_meas[W-1]}}, i_meas};
        upper = ref_x + BAND_X;
        lower = ref_x - BAND_X;
        below = cur_x < lower;
        above = cur_x > upper;
    end

endmodule

// File: rtl/hcb_qualify.sv
module hcb_qualify #(
    parameter int W        = 16,
    parameter int DEAD_LSB = 77,
    parameter int ARM_LSB  = 13824
) (
    input  logic signed [W-1:0] ref_smp,
    input  logic signed [W-1:0] vdc_meas,
    output logic                armed,
    output logic                dead
);
    localparam int XW = W + 1;
    localparam logic signed [XW-1:0] DEAD_X = $signed(XW'(DEAD_LSB));
    localparam logic signed [XW-1:0] ARM_X  = $signed(XW'(ARM_LSB));

    logic signed [XW-1:0] ref_x;
    logic signed [XW-1:0] mag;
    logic signed [XW-1:0] vdc_x;

    always_comb begin
        ref_x = {ref_smp[W-1], ref_smp};
        vdc_x = {vdc_meas[W-1], vdc_meas};
        mag   = (ref_x < 0) ? -ref_x : ref_x;
        dead  = mag <= DEAD_X;
        armed = vdc_x > ARM_X;
    end

endmodule

// File: rtl/hcb_fsm.sv
module hcb_fsm
    import hcb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    input  logic armed,
    input  logic dead,
    input  logic below,
    input  logic above,
    output logic gate_pos,
    output logic gate_neg
);
    band_state_t state;
    band_state_t nxt;

    function automatic band_state_t pick(input band_state_t held,
                                         input logic d, input logic b,
                                         input logic a);
        band_state_t r;
        if (d)      r = ST_IDLE;
        else if (b) r = ST_POS;
        else if (a) r = ST_NEG;
        else        r = held;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (!armed)         nxt = ST_OFF;
                else if (smp_valid) nxt = pick(ST_IDLE, dead, below, above);
                else                nxt = ST_IDLE;
            end
            ST_IDLE, ST_POS, ST_NEG: begin
                if (!armed)         nxt = ST_OFF;
                else if (smp_valid) nxt = pick(state, dead, below, above);
                else                nxt = state;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        gate_pos = 1'b0;
        gate_neg = 1'b0;
        unique case (state)
            ST_POS:           gate_pos = 1'b1;
            ST_NEG:           gate_neg = 1'b1;
            ST_OFF, ST_IDLE:  ;
            default:          ;
        endcase
    end

endmodule

// File: rtl/hcb_ctrl.sv
module hcb_ctrl #(
    parameter int W        = 16,
    parameter int BAND_LSB = 256,
    parameter int DEAD_LSB = 77,
    parameter int ARM_LSB  = 13824
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] i_meas,
    input  logic signed [W-1:0] ref_smp,
    input  logic                smp_valid,
    input  logic signed [W-1:0] vdc_meas,
    output logic                gate_pos,
    output logic                gate_neg
);
    logic below, above, armed, dead;

    hcb_window #(.W(W), .BAND_LSB(BAND_LSB)) u_window (
        .i_meas (i_meas),
        .ref_smp(ref_smp),
        .below  (below),
        .above  (above)
    );

    hcb_qualify #(.W(W), .DEAD_LSB(DEAD_LSB), .ARM_LSB(ARM_LSB)) u_qualify (
        .ref_smp (ref_smp),
        .vdc_meas(vdc_meas),
        .armed   (armed),
        .dead    (dead)
    );

    hcb_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .armed    (armed),
        .dead     (dead),
        .below    (below),
        .above    (above),
        .gate_pos (gate_pos),
        .gate_neg (gate_neg)
    );

endmodule

// File: rtl/hcb_ctrl_chk.sv
module hcb_ctrl_chk #(
    parameter int W        = 16,
    parameter int BAND_LSB = 256,
    parameter int DEAD_LSB = 77,
    parameter int ARM_LSB  = 13824
) (
    input logic                clk,
    input logic                rst,
    input logic signed [W-1:0] i_meas,
    input logic signed [W-1:0] ref_smp,
    input logic                smp_valid,
    input logic signed [W-1:0] vdc_meas,
    input logic                gate_pos,
    input logic                gate_neg
);
    int cur_i, ref_i, vdc_i, mag_i;
    logic armed_c, dead_c;

    always_comb begin
        cur_i   = int'(i_meas);
        ref_i   = int'(ref_smp);
        vdc_i   = int'(vdc_meas);
        mag_i   = (ref_i < 0) ? -ref_i : ref_i;
        armed_c = vdc_i > ARM_LSB;
        dead_c  = mag_i <= DEAD_LSB;
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(gate_pos && gate_neg));

    p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
        !armed_c |=> (!gate_pos && !gate_neg));

    p_dead_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && armed_c && dead_c) |=> (!gate_pos && !gate_neg));

    p_pos_r2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && armed_c && !dead_c && (cur_i < ref_i - BAND_LSB))
        |=> (gate_pos && !gate_neg));

    p_neg_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && armed_c && !dead_c && (cur_i > ref_i + BAND_LSB))
        |=> (gate_neg && !gate_pos));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && armed_c) |=> ($stable(gate_pos) && $stable(gate_neg)));

endmodule

bind hcb_ctrl hcb_ctrl_chk #(
    .W(W), .BAND_LSB(BAND_LSB), .DEAD_LSB(DEAD_LSB), .ARM_LSB(ARM_LSB)
) u_chk (
    .clk(clk), .rst(rst), .i_meas(i_meas), .ref_smp(ref_smp),
    .smp_valid(smp_valid), .vdc_meas(vdc_meas),
    .gate_pos(gate_pos), .gate_neg(gate_neg)
);

// File: tb/hcb_ctrl_bench.sv
module hcb_ctrl_bench;
    localparam int W    = 16;
    localparam int BAND = 256;
    localparam int DEAD = 77;
    localparam int ARM  = 13824;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [W-1:0] i_meas = '0;
    logic signed [W-1:0] ref_smp = '0;
    logic smp_valid = 1'b0;
    logic signed [W-1:0] vdc_meas = '0;
    logic gate_pos, gate_neg;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hcb_ctrl #(.W(W), .BAND_LSB(BAND), .DEAD_LSB(DEAD), .ARM_LSB(ARM)) u_hcb_ctrl (
        .clk(clk), .rst(rst), .i_meas(i_meas), .ref_smp(ref_smp),
        .smp_valid(smp_valid), .vdc_meas(vdc_meas),
        .gate_pos(gate_pos), .gate_neg(gate_neg)
    );

    task automatic chk(input string req, input logic ep, input logic en);
        n_run++;
        if (gate_pos !== ep || gate_neg !== en) begin
            n_fail++;
            $display("FAIL %s: pos/neg = %b%b, expected %b%b", req, gate_pos, gate_neg, ep, en);
        end
    endtask

    task automatic smp(input int cur, input int rf);
        @(negedge clk);
        i_meas = W'(cur); ref_smp = W'(rf); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic set_vdc(input int v);
        @(negedge clk);
        vdc_meas = W'(v);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", 1'b0, 1'b0);
    endtask

    task automatic t_arm;
        set_vdc(ARM);
        smp(0, 2560);
        chk("R6 link at limit", 1'b0, 1'b0);
        set_vdc(ARM + 1);
        chk("R6 armed no sample", 1'b0, 1'b0);
        smp(0, 2560);
        chk("R2 below band", 1'b1, 1'b0);
    endtask

    task automatic t_band;
        smp(2560 + 300, 2560);
        chk("R3 above band", 1'b0, 1'b1);
        smp(2560, 2560);
        chk("R4 hold neg", 1'b0, 1'b1);
        smp(2000, 2560);
        chk("R2 below again", 1'b1, 1'b0);
        smp(2560 + 100, 2560);
        chk("R4 hold pos", 1'b1, 1'b0);
    endtask

    task automatic t_edges;
        smp(2560 + BAND, 2560);
        chk("R5 upper edge", 1'b1, 1'b0);
        smp(2560 + BAND + 1, 2560);
        chk("R5 past upper", 1'b0, 1'b1);
        smp(2560 - BAND, 2560);
        chk("R5 lower edge", 1'b0, 1'b1);
        smp(2560 - BAND - 1, 2560);
        chk("R5 past lower", 1'b1, 1'b0);
    endtask

    task automatic t_novalid;
        smp(5000, 2560);
        @(negedge clk);
        i_meas = W'(-3000); ref_smp = W'(1000);
        repeat (3) @(negedge clk);
        chk("R9 no strobe", 1'b0, 1'b1);
    endtask

    task automatic t_dead;
        smp(-1000, DEAD);
        chk("R7 ref +dead", 1'b0, 1'b0);
        smp(2000, 500);
        chk("R3 reenter", 1'b0, 1'b1);
        smp(1000, -DEAD);
        chk("R7 ref -dead", 1'b0, 1'b0);
        smp(-1000, DEAD + 1);
        chk("R7 just outside", 1'b1, 1'b0);
    endtask

    task automatic t_negref;
        smp(-896, -512);
        chk("R10 below neg ref", 1'b1, 1'b0);
        smp(-600, -512);
        chk("R10 hold neg ref", 1'b1, 1'b0);
        smp(-200, -512);
        chk("R10 above neg ref", 1'b0, 1'b1);
    endtask

    task automatic t_disarm;
        smp(0, 2560);
        chk("R2 pre disarm", 1'b1, 1'b0);
        @(negedge clk);
        vdc_meas = '0;
        @(negedge clk);
        chk("R6 disarm", 1'b0, 1'b0);
        vdc_meas = W'(15360);
        repeat (3) @(negedge clk);
        chk("R6 rearm waits", 1'b0, 1'b0);
        smp(0, 2560);
        chk("R6 resume", 1'b1, 1'b0);
    endtask

    task automatic t_sweep;
        int st = 0;
        for (int k = 0; k < 60; k++) begin
            int rf = ((k % 20) - 10) * 40;
            int cur = rf + (((k * 7) % 9) - 4) * 100;
            int mag = (rf < 0) ? -rf : rf;
            logic ep, en;
            smp(cur, rf);
            if (mag <= DEAD)            st = 0;
            else if (cur < rf - BAND)   st = 1;
            else if (cur > rf + BAND)   st = 2;
            ep = (st == 1);
            en = (st == 2);
            chk("R8 sweep", ep, en);
            if (gate_pos && gate_neg) begin
                n_fail++;
                $display("FAIL R8: both gates 1, expected at most one");
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_arm();
        t_band();
        t_edges();
        t_novalid();
        t_dead();
        t_negref();
        t_disarm();
        t_sweep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule